// File: doc/BRIEF.md
# Input-Queued Packet Switch with Per-Output Arbitration

This block moves single-flit packets between a set of ports. Every input has a small queue of its own and a routing unit that looks only at the flit at the front of that queue. The routing unit reads the destination field and raises a request to exactly one output. Each output has its own arbiter, which picks one of the inputs requesting it. The winning flit then crosses an AND-OR crossbar to that output. A parameter selects how the arbiters choose: lowest input index, longest-waiting head, or a pseudo-random rotating start point taken from a shift-register generator.

Only the front flit of a queue can compete. A front flit that loses arbitration, or whose output is not ready, therefore stalls every flit queued behind it, even when those flits are bound for idle outputs. This head-of-line blocking is part of the intended behaviour. Each flit carries its destination port number in its top bits and its payload in the bits below. A flit leaves its queue only in a cycle where it is granted and the chosen output has `out_ready` high.

Top module: `sw_ib_switch`

## Requirements
- R1: When reset is released, every `out_valid` bit is low and every `in_ready` bit is high.
- R2: A flit is delivered unchanged on output d, where d is its top DEST_W bits; the payload is the low DATA_W bits. Port p's flit occupies bits [p*FLIT_W +: FLIT_W] of `in_flit` and `out_flit`. Each accepted flit is delivered exactly once.
- R3: An input queue holds DEPTH flits. `in_ready` for an input is low exactly while DEPTH flits are held, and a flit offered while it is low is dropped. Flits from one input to one output leave in arrival order.
- R4: At most one input is granted per output per cycle. `out_valid[o]` is high in any cycle in which at least one queue front is destined for o.
- R5: While `out_valid[o]` is high and `out_ready[o]` is low, the presented flit stays queued and `out_valid[o]` stays high.
- R6: With ARB_MODE = ARB_FIXED (0), the requesting input with the lowest index wins.
- R7: With ARB_MODE = ARB_OLDEST (1), the front flit that has waited the most cycles since it reached the front of its queue wins. Ties go to the lowest index.
- R8: With ARB_MODE = ARB_RANDOM (2), the arbiter starts its search at a pseudo-random input and takes the first requester from there. Service interleaves across inputs, and no flit is lost or reordered within an input.
- R9: A flit behind a stalled front flit is not offered, even when its own output is idle. It is delivered once the front flit has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORT | Per-input flit valid |
| in_ready | output | NPORT | Per-input queue has space |
| in_flit | input | NPORT*FLIT_W | Packed input flits, {dest, payload} per port |
| out_valid | output | NPORT | Per-output flit valid |
| out_ready | input | NPORT | Per-output sink ready |
| out_flit | output | NPORT*FLIT_W | Packed output flits |

## Verification
The hardest condition to reach from the ports is a queued flit whose output is free but which still cannot move. That only happens when the front flit of its queue has been refused for several cycles. The stimulus sets this up by holding one output's ready low, putting two front flits on that output, and placing a third flit bound for an idle output behind the losing one. The longest-waiting policy needs ages that differ by a known amount. For that, an early flit is left stalled for a counted number of cycles before a lower-index competitor arrives.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [1:0] {
    ARB_FIXED  = 2'd0,
    ARB_OLDEST = 2'd1,
    ARB_RANDOM = 2'd2
  } arb_mode_e;

  typedef enum logic {
    RT_IDLE = 1'b0,
    RT_WAIT = 1'b1
  } rt_state_e;

endpackage

// File: rtl/sw_flit_fifo.sv
module sw_flit_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rd_pop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push, pop;

  assign wr_ready = (count != CNT_W'(DEPTH));
  assign rd_valid = (count != '0);
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_pop && rd_valid;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  p_full_drops_r3: assert property (@(posedge clk) disable iff (rst)
    (!wr_ready && !rd_pop) |=> (count == $past(count)));
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    rd_pop |-> rd_valid);

endmodule

// File: rtl/sw_route_unit.sv
module sw_route_unit import sw_pkg::*; #(
  parameter int NPORT  = 4,
  parameter int DEST_W = 2,
  parameter int AGE_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic [DEST_W-1:0] head_dest,
  input  logic              popped,
  output logic [NPORT-1:0]  req,
  output logic [AGE_W-1:0]  age
);
  rt_state_e state;

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      req[o] = head_valid && (head_dest == DEST_W'(o));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RT_IDLE;
      age   <= '0;
    end else if (!head_valid || popped) begin
      state <= RT_IDLE;
      age   <= '0;
    end else begin
      case (state)
        RT_IDLE: begin
          state <= RT_WAIT;
          age   <= AGE_W'(1);
        end
        default: begin
          state <= RT_WAIT;
          if (age != '1) age <= age + 1'b1;
        end
      endcase
    end
  end

  p_one_req_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req));
  p_age_clear_r7: assert property (@(posedge clk) disable iff (rst)
    popped |=> (age == '0));

endmodule

// File: rtl/sw_out_arb.sv
module sw_out_arb import sw_pkg::*; #(
  parameter int          NPORT    = 4,
  parameter int          AGE_W    = 6,
  parameter arb_mode_e   ARB_MODE = ARB_FIXED,
  parameter logic [15:0] SEED     = 16'hACE1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NPORT-1:0]            req,
  input  logic [NPORT-1:0][AGE_W-1:0] age,
  output logic [NPORT-1:0]            gnt
);
  generate
    if (ARB_MODE == ARB_OLDEST) begin : g_oldest
      int   best;
      logic found;
      logic unused_in;
      assign unused_in = ^{clk, rst};
      always_comb begin
        gnt   = '0;
        found = 1'b0;
        best  = 0;
        for (int i = 0; i < NPORT; i++) begin
          if (req[i] && (!found || (age[i] > age[best]))) begin
            found = 1'b1;
            best  = i;
          end
        end
        if (found) gnt[best] = 1'b1;
      end
    end else if (ARB_MODE == ARB_RANDOM) begin : g_random
      logic [15:0] lfsr;
      int          off;
      int          idx;
      logic        found;
      logic        unused_in;
      assign unused_in = ^age;
      always_ff @(posedge clk) begin
        if (rst) lfsr <= SEED;
        else     lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      end
      always_comb begin
        gnt   = '0;
        found = 1'b0;
        idx   = 0;
        off   = int'(lfsr % 16'(NPORT));
        for (int k = 0; k < NPORT; k++) begin
          idx = (off + k) % NPORT;
          if (req[idx] && !found) begin
            found    = 1'b1;
            gnt[idx] = 1'b1;
          end
        end
      end
      p_lfsr_live_r8: assert property (@(posedge clk) disable iff (rst)
        lfsr != 16'h0000);
    end else begin : g_fixed
      logic found;
      logic unused_in;
      assign unused_in = ^{clk, rst, age};
      always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
          if (req[i] && !found) begin
            found  = 1'b1;
            gnt[i] = 1'b1;
          end
        end
      end
      p_lowest_wins_r6: assert property (@(posedge clk) disable iff (rst)
        gnt == (req & (~req + 1'b1)));
    end
  endgenerate

  p_onehot_gnt_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  p_gnt_subset_r4: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
  p_work_conserving_r4: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (gnt != '0));

endmodule

// File: rtl/sw_crossbar.sv
module sw_crossbar #(
  parameter int NPORT = 4,
  parameter int WIDTH = 10
) (
  input  logic [NPORT-1:0][WIDTH-1:0] data_in,
  input  logic [NPORT-1:0][NPORT-1:0] sel,
  output logic [NPORT-1:0][WIDTH-1:0] data_out
);
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      data_out[o] = '0;
      for (int i = 0; i < NPORT; i++) begin
        data_out[o] = data_out[o] | ({WIDTH{sel[o][i]}} & data_in[i]);
      end
    end
  end
endmodule

// File: rtl/sw_ib_switch.sv
module sw_ib_switch import sw_pkg::*; #(
  parameter int        NPORT    = 4,
  parameter int        DEPTH    = 4,
  parameter int        DATA_W   = 8,
  parameter int        AGE_W    = 6,
  parameter arb_mode_e ARB_MODE = ARB_FIXED,
  localparam int       DEST_W   = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int       FLIT_W   = DEST_W + DATA_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT-1:0]        in_ready,
  input  logic [NPORT*FLIT_W-1:0] in_flit,
  output logic [NPORT-1:0]        out_valid,
  input  logic [NPORT-1:0]        out_ready,
  output logic [NPORT*FLIT_W-1:0] out_flit
);
  logic [NPORT-1:0][FLIT_W-1:0] head_flit;
  logic [NPORT-1:0][FLIT_W-1:0] xbar_out;
  logic [NPORT-1:0]             head_valid;
  logic [NPORT-1:0]             pop;
  logic [NPORT-1:0][NPORT-1:0]  req_in, req_out, gnt_in, gnt_out;
  logic [NPORT-1:0][AGE_W-1:0]  age;

  genvar i, o;
  generate
    for (i = 0; i < NPORT; i++) begin : g_in
      sw_flit_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (in_valid[i]),
        .wr_ready (in_ready[i]),
        .wr_data  (in_flit[i*FLIT_W +: FLIT_W]),
        .rd_valid (head_valid[i]),
        .rd_data  (head_flit[i]),
        .rd_pop   (pop[i])
      );

      sw_route_unit #(.NPORT(NPORT), .DEST_W(DEST_W), .AGE_W(AGE_W)) u_route (
        .clk        (clk),
        .rst        (rst),
        .head_valid (head_valid[i]),
        .head_dest  (head_flit[i][FLIT_W-1 -: DEST_W]),
        .popped     (pop[i]),
        .req        (req_in[i]),
        .age        (age[i])
      );

      assign pop[i] = |(gnt_in[i] & out_ready);
    end

    for (o = 0; o < NPORT; o++) begin : g_out
      sw_out_arb #(
        .NPORT    (NPORT),
        .AGE_W    (AGE_W),
        .ARB_MODE (ARB_MODE),
        .SEED     (16'hACE1 ^ 16'(o + 1))
      ) u_arb (
        .clk (clk),
        .rst (rst),
        .req (req_out[o]),
        .age (age),
        .gnt (gnt_out[o])
      );

      assign out_valid[o] = |gnt_out[o];

      p_hold_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid[o] && !out_ready[o]) |=> out_valid[o]);
    end
  endgenerate

  always_comb begin
    for (int a = 0; a < NPORT; a++) begin
      for (int b = 0; b < NPORT; b++) begin
        req_out[a][b] = req_in[b][a];
        gnt_in[a][b]  = gnt_out[b][a];
      end
    end
  end

  sw_crossbar #(.NPORT(NPORT), .WIDTH(FLIT_W)) u_xbar (
    .data_in  (head_flit),
    .sel      (gnt_out),
    .data_out (xbar_out)
  );

  assign out_flit = xbar_out;

  p_pop_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
    ((pop & ~head_valid) == '0));

endmodule

// File: tb/tb_sw_ib_switch.sv
module tb_sw_ib_switch;
  import sw_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int FW = 10;
  localparam int NVEC = 7;

  // {in mask, dests d3..d0, expected out_valid, winners w3..w0}
  localparam logic [23:0] VEC [NVEC] = '{
    24'hFE4FE4, 24'hFAA400, 24'hE3C943, 24'hA88410,
    24'h101200, 24'hC4030E, 24'hF0F902
  };

  logic clk, rst;
  logic [NP-1:0]    in_valid, out_ready;
  logic [NP*FW-1:0] in_flit;
  logic [NP-1:0]    in_ready_f, in_ready_a, in_ready_r;
  logic [NP-1:0]    out_valid_f, out_valid_a, out_valid_r;
  logic [NP*FW-1:0] out_flit_f, out_flit_a, out_flit_r;

  int n_chk, n_bad, got, tot;
  logic done, mixed;
  logic [23:0] vec;
  logic [7:0]  dsts, wins, pl;
  logic [3:0]  vmask, exp_ov;
  logic [1:0]  ii;
  int nk [NP];

  sw_ib_switch #(.ARB_MODE(ARB_FIXED)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_f), .in_flit(in_flit),
    .out_valid(out_valid_f), .out_ready(out_ready), .out_flit(out_flit_f));
  sw_ib_switch #(.ARB_MODE(ARB_OLDEST)) dut_age (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_a), .in_flit(in_flit),
    .out_valid(out_valid_a), .out_ready(out_ready), .out_flit(out_flit_a));
  sw_ib_switch #(.ARB_MODE(ARB_RANDOM)) dut_rnd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_r), .in_flit(in_flit),
    .out_valid(out_valid_r), .out_ready(out_ready), .out_flit(out_flit_r));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input int p, input logic [1:0] d, input logic [7:0] pay);
    in_flit[p*FW +: FW] = {d, pay};
  endtask

  initial begin
    done = 1'b0;
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst = 1'b1; in_valid = '0; out_ready = '1; in_flit = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 out_valid after reset", out_valid_f, 0);
    check("R1 in_ready after reset", in_ready_f, 4'hF);
    check("R1 out_valid after reset (oldest)", out_valid_a, 0);
    check("R1 in_ready after reset (random)", in_ready_r, 4'hF);

    // table of single-cycle injections, fixed priority
    for (int v = 0; v < NVEC; v++) begin
      vec = VEC[v];
      vmask = vec[23:20]; dsts = vec[19:12]; exp_ov = vec[11:8]; wins = vec[7:0];
      out_ready = '1;
      for (int i = 0; i < NP; i++) put(i, dsts[i*2 +: 2], {4'(v), 2'b00, 2'(i)});
      in_valid = vmask;
      @(negedge clk);
      in_valid = '0;
      check("R4 out_valid mask", out_valid_f, exp_ov);
      for (int o = 0; o < NP; o++)
        if (exp_ov[o])
          check("R6 lowest index wins", out_flit_f[o*FW +: FW],
                {2'(o), 4'(v), 2'b00, wins[o*2 +: 2]});
      got = 0;
      for (int c = 0; c < 6; c++) begin
        got += $countones(out_valid_f);
        @(negedge clk);
      end
      check("R2 each flit delivered once", got, $countones(vmask));
    end

    // queue fill, drop when full, hold under back-pressure, order
    out_ready = '0;
    for (int k = 0; k < 5; k++) begin
      put(0, 2'd2, 8'(8'h10 + k));
      in_valid = 4'b0001;
      @(negedge clk);
      if (k == 0) check("R2 routed to dest 2", out_flit_f[2*FW +: FW], 10'h210);
      if (k == 3) check("R3 in_ready low when full", in_ready_f[0], 0);
    end
    in_valid = '0;
    repeat (3) @(negedge clk);
    check("R5 valid held while not ready", out_valid_f[2], 1);
    check("R5 flit held while not ready", out_flit_f[2*FW +: 8], 8'h10);
    out_ready = '1;
    got = 0;
    for (int c = 0; c < 8; c++) begin
      if (out_valid_f[2]) begin
        check("R3 arrival order", out_flit_f[2*FW +: 8], 32'(8'h10 + got));
        got++;
      end
      @(negedge clk);
    end
    check("R3 extra flit dropped", got, 4);

    // head-of-line blocking
    out_ready = 4'b1101;
    put(0, 2'd1, 8'h20); put(1, 2'd1, 8'h21);
    in_valid = 4'b0011;
    @(negedge clk);
    put(1, 2'd3, 8'h22);
    in_valid = 4'b0010;
    @(negedge clk);
    in_valid = '0;
    repeat (2) @(negedge clk);
    check("R6 input 0 holds output 1", out_flit_f[1*FW +: 8], 8'h20);
    check("R9 flit behind blocked head not offered", out_valid_f[3], 0);
    out_ready = '1;
    got = 0;
    for (int c = 0; c < 6; c++) begin
      got += int'(out_valid_f[3]);
      @(negedge clk);
    end
    check("R9 blocked flit later delivered", got, 1);

    // longest-waiting head wins
    out_ready = 4'b1110;
    put(3, 2'd0, 8'h30);
    in_valid = 4'b1000;
    @(negedge clk);
    in_valid = '0;
    repeat (2) @(negedge clk);
    put(0, 2'd0, 8'h31);
    in_valid = 4'b0001;
    @(negedge clk);
    in_valid = '0;
    check("R7 older head wins", out_flit_a[0 +: 8], 8'h30);
    check("R6 fixed mode picks input 0", out_flit_f[0 +: 8], 8'h31);
    out_ready = '1;
    got = 0;
    for (int c = 0; c < 4; c++) begin
      if (out_valid_a[0]) begin
        check("R7 service order", out_flit_a[0 +: 8], (got == 0) ? 32'h30 : 32'h31);
        got++;
      end
      @(negedge clk);
    end
    check("R7 both delivered", got, 2);
    out_ready = 4'b0111;
    put(1, 2'd3, 8'h41); put(2, 2'd3, 8'h42);
    in_valid = 4'b0110;
    @(negedge clk);
    in_valid = '0;
    @(negedge clk);
    check("R7 equal age goes to lowest index", out_flit_a[3*FW +: 8], 8'h41);
    out_ready = '1;
    repeat (4) @(negedge clk);

    // random start point
    out_ready = '0;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < NP; i++) put(i, 2'd0, 8'(8'h40 + k*4 + i));
      in_valid = '1;
      @(negedge clk);
    end
    in_valid = '0;
    out_ready = '1;
    for (int i = 0; i < NP; i++) nk[i] = 0;
    tot = 0; mixed = 1'b0;
    for (int c = 0; c < 24; c++) begin
      if (out_valid_r[0]) begin
        pl = out_flit_r[7:0];
        ii = pl[1:0];
        check("R8 per-input order kept", 32'(pl[3:2]), nk[ii]);
        for (int j = 0; j < NP; j++)
          if (j < int'(ii) && nk[j] < 4) mixed = 1'b1;
        nk[ii] = nk[ii] + 1;
        tot++;
      end
      @(negedge clk);
    end
    check("R8 all flits delivered", tot, 16);
    check("R8 service interleaves inputs", mixed, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule